// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a serial-bus target that gives a host read and write access to a bank of byte-wide configuration registers. The host moves several bytes per transaction. A transfer names a starting register and then walks forward through the bank, one register per byte. The target watches SCL and SDA through synchronizers, recognises start, repeated start and stop conditions, and answers only to its own address byte. It pulls SDA low through an enable output that drives an open-drain pad.

To write, the host sends the address with the write bit, then a starting index, then a byte count, then that many data bytes. To read, the host first sends the write address and the starting index. It then issues a repeated start and sends the address with the read bit. The target replies with the content of its count register, followed by the registers from the starting index onward. The host acknowledges each byte and ends the read by refusing the last one.

The register bank appears in parallel as one flat output vector. A one-cycle strobe, carrying the index and data, marks each write into the bank.

Top module: `smbus_idx_target`

## Requirements
- R1: The target acknowledges the address byte 0xDC (7-bit address 0x6E, R/W bit 0 = write) and 0xDD (R/W bit 1 = read). It does not acknowledge any other address byte, and it leaves SDA released for the rest of that transaction.
- R2: In a write transaction, the byte after the address loads the register pointer (low 4 bits), and the next byte sets the byte count X. The following X data bytes are stored in registers N, N+1, … N+X-1.
- R3: During a write, the target acknowledges the address, index and count bytes, and every data byte within the count, by holding SDA low in the ninth clock.
- R4: Data bytes beyond the count X are not acknowledged and are not stored.
- R5: The register pointer wraps from index 15 to index 0, for both writes and reads.
- R6: After a repeated start and the read address, the target first sends the byte held in register index 8, MSB first. It then sends registers starting at the pointer, advancing one index for each byte the host acknowledges.
- R7: After reset, register index 8 holds 0x10, all other registers hold 0x00, and SDA is released. A read with no index phase therefore starts at index 0 and reports a count of 16.
- R8: When the host does not acknowledge a read byte, the target releases SDA and ignores further clocks until a start or stop. A stop always returns the target to idle with SDA released.
- R9: A repeated start keeps the register pointer loaded by the preceding write phase.
- R10: The target changes its SDA drive only while SCL is low, and it samples SDA on the rising edge of SCL.
- R11: Each stored byte raises the write strobe for exactly one clock cycle, with its index and data on the write port. The register bank holds that data from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_strobe | output | 1 | One-cycle pulse for each stored byte |
| wr_index | output | 4 | Register index of the stored byte |
| wr_data | output | 8 | Value of the stored byte |
| reg_flat | output | 128 | All registers; register k in bits 8k+7:8k |

## Verification
The checker assumes that every SCL high or low phase lasts well beyond the synchronizer latency of a few clock cycles. It also assumes that the host changes SDA only while SCL is low, except when it forms a start or stop, and that it never signals a stop while the target is holding SDA low. The bench drives SCL with quarter periods of eight system clocks. It moves its own SDA drive one quarter after each falling SCL edge. It issues starts and stops only after the target's acknowledge slot has ended, so the property that the drive rises only during SCL low, and the property that a stop releases the line, are tested under legal bus timing.

// File: rtl/smbus_idx_pkg.sv
package smbus_idx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_WAIT
   } link_st_t;

   typedef enum logic [2:0] {
      PH_ADDR,
      PH_INDEX,
      PH_COUNT,
      PH_WDATA,
      PH_RDATA
   } phase_t;

   function automatic phase_t next_rx_phase(input phase_t p);
      case (p)
         PH_ADDR:  return PH_INDEX;
         PH_INDEX: return PH_COUNT;
         default:  return PH_WDATA;
      endcase
   endfunction

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("smbus_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_sh;
   logic [STAGES-1:0] sda_sh;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_in};
         sda_sh <= {sda_sh[STAGES-2:0], sda_in};
         scl_q  <= scl_s;
         sda_q  <= sda_s;
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda_s     = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smbus_reg_bank.sv
module smbus_reg_bank #(
   parameter int         NUM_REGS    = 16,
   parameter int         IDX_W       = 4,
   parameter int         COUNT_IDX   = 8,
   parameter logic [7:0] COUNT_RESET = 8'h10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [IDX_W-1:0]      widx,
   input  logic [7:0]            wdata,
   output logic [NUM_REGS*8-1:0] flat
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] RST_VAL = (g == COUNT_IDX) ? COUNT_RESET : 8'h00;
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RST_VAL;
         else if (we && (widx == IDX_W'(g)))
            q <= wdata;
      end
      assign flat[g*8 +: 8] = q;
   end

endmodule

// File: rtl/smbus_idx_fsm.sv
module smbus_idx_fsm
   import smbus_idx_pkg::*;
#(
   parameter int         NUM_REGS  = 16,
   parameter int         IDX_W     = 4,
   parameter logic [6:0] DEV_ADDR  = 7'h6E
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_rise,
   input  logic                  scl_fall,
   input  logic                  sda_s,
   input  logic                  start_det,
   input  logic                  stop_det,
   input  logic [7:0]            count_val,
   input  logic [NUM_REGS*8-1:0] reg_flat,
   output logic                  sda_low,
   output logic                  wr_en,
   output logic [IDX_W-1:0]      wr_idx,
   output logic [7:0]            wr_data
);

   link_st_t         st;
   phase_t           ph;
   logic [2:0]       bit_cnt;
   logic             byte_done;
   logic [7:0]       shreg;
   logic [7:0]       txbyte;
   logic [IDX_W-1:0] ptr;
   logic [7:0]       remain;
   logic             go_tx;
   logic [7:0]       cur_reg;

   assign cur_reg = reg_flat[{ptr, 3'b000} +: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ph        <= PH_ADDR;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         shreg     <= '0;
         txbyte    <= '0;
         ptr       <= '0;
         remain    <= '0;
         go_tx     <= 1'b0;
         sda_low   <= 1'b0;
         wr_en     <= 1'b0;
         wr_idx    <= '0;
         wr_data   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            st      <= ST_IDLE;
            sda_low <= 1'b0;
         end else if (start_det) begin
            st        <= ST_RX;
            ph        <= PH_ADDR;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            go_tx     <= 1'b0;
            sda_low   <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) byte_done <= 1'b1;
                  end else if (scl_fall && byte_done) begin
                     byte_done <= 1'b0;
                     st        <= ST_RX_ACK;
                     case (ph)
                        PH_ADDR: begin
                           if (shreg[7:1] == DEV_ADDR) begin
                              sda_low <= 1'b1;
                              go_tx   <= shreg[0];
                           end else begin
                              st <= ST_WAIT;
                           end
                        end
                        PH_INDEX: begin
                           sda_low <= 1'b1;
                           ptr     <= shreg[IDX_W-1:0];
                        end
                        PH_COUNT: begin
                           sda_low <= 1'b1;
                           remain  <= shreg;
                        end
                        PH_WDATA: begin
                           if (remain != 8'd0) begin
                              sda_low <= 1'b1;
                              wr_en   <= 1'b1;
                              wr_idx  <= ptr;
                              wr_data <= shreg;
                              ptr     <= ptr + 1'b1;
                              remain  <= remain - 8'd1;
                           end else begin
                              st <= ST_WAIT;
                           end
                        end
                        default: st <= ST_WAIT;
                     endcase
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     go_tx   <= 1'b0;
                     if (go_tx) begin
                        st      <= ST_TX;
                        ph      <= PH_RDATA;
                        txbyte  <= count_val;
                        sda_low <= ~count_val[7];
                     end else begin
                        st      <= ST_RX;
                        ph      <= next_rx_phase(ph);
                        sda_low <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) byte_done <= 1'b1;
                  end else if (scl_fall) begin
                     if (byte_done) begin
                        byte_done <= 1'b0;
                        sda_low   <= 1'b0;
                        st        <= ST_TX_ACK;
                     end else begin
                        sda_low <= ~txbyte[3'd7 - bit_cnt];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     if (sda_s) begin
                        st <= ST_WAIT;
                     end else begin
                        txbyte <= cur_reg;
                        ptr    <= ptr + 1'b1;
                     end
                  end else if (scl_fall) begin
                     st      <= ST_TX;
                     bit_cnt <= '0;
                     sda_low <= ~txbyte[7];
                  end
               end
               default: sda_low <= 1'b0;
            endcase
         end
      end
   end

endmodule

// File: rtl/smbus_idx_target.sv
module smbus_idx_target #(
   parameter int         NUM_REGS    = 16,
   parameter int         COUNT_IDX   = 8,
   parameter logic [7:0] COUNT_RESET = 8'h10,
   parameter logic [6:0] DEV_ADDR    = 7'h6E,
   parameter int         SYNC_STAGES = 2,
   localparam int        IDX_W       = $clog2(NUM_REGS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   output logic                  sda_drive_low,
   output logic                  wr_strobe,
   output logic [IDX_W-1:0]      wr_index,
   output logic [7:0]            wr_data,
   output logic [NUM_REGS*8-1:0] reg_flat
);

   if ((1 << IDX_W) != NUM_REGS) begin : g_bad_depth
      $error("smbus_idx_target: NUM_REGS must be a power of two");
   end
   if (COUNT_IDX >= NUM_REGS) begin : g_bad_count
      $error("smbus_idx_target: COUNT_IDX outside register bank");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [7:0] count_val;

   smbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   assign count_val = reg_flat[COUNT_IDX*8 +: 8];

   smbus_idx_fsm #(
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W),
      .DEV_ADDR (DEV_ADDR)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_s     (sda_s),
      .start_det (start_det),
      .stop_det  (stop_det),
      .count_val (count_val),
      .reg_flat  (reg_flat),
      .sda_low   (sda_drive_low),
      .wr_en     (wr_strobe),
      .wr_idx    (wr_index),
      .wr_data   (wr_data)
   );

   smbus_reg_bank #(
      .NUM_REGS    (NUM_REGS),
      .IDX_W       (IDX_W),
      .COUNT_IDX   (COUNT_IDX),
      .COUNT_RESET (COUNT_RESET)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_strobe),
      .widx  (wr_index),
      .wdata (wr_data),
      .flat  (reg_flat)
   );

endmodule

// File: rtl/smbus_idx_target_chk.sv
module smbus_idx_target_chk #(
   parameter int  NUM_REGS = 16,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_s,
   input logic                  stop_det,
   input logic                  sda_drive_low,
   input logic                  wr_strobe,
   input logic [IDX_W-1:0]      wr_index,
   input logic [7:0]            wr_data,
   input logic [NUM_REGS*8-1:0] reg_flat
);

   logic [IDX_W-1:0] last_idx;
   logic [7:0]       last_data;
   logic [7:0]       at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_idx  <= '0;
         last_data <= '0;
      end else if (wr_strobe) begin
         last_idx  <= wr_index;
         last_data <= wr_data;
      end
   end

   assign at_last = reg_flat[{last_idx, 3'b000} +: 8];

   // R10: the target starts pulling SDA only during the SCL low phase
   assert_drive_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> !scl_s);

   // R11: a strobed byte is present in the bank on the following cycle
   assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> (at_last == last_data));

   // R8: a stop condition leaves SDA released
   assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_drive_low);

   // R2: bytes are committed at the falling SCL edge that closes a byte
   assert_strobe_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> !scl_s);

   // R11: the strobe never lasts two cycles
   assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !wr_strobe);

endmodule

bind smbus_idx_target smbus_idx_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_s         (scl_s),
   .stop_det      (stop_det),
   .sda_drive_low (sda_drive_low),
   .wr_strobe     (wr_strobe),
   .wr_index      (wr_index),
   .wr_data       (wr_data),
   .reg_flat      (reg_flat)
);

// File: tb/test_smbus_idx_target.sv
`timescale 1ns/1ps
module test_smbus_idx_target;

   localparam int Q = 8;
   localparam int NV = 5;
   // {index, count, first data byte}; successive bytes increment by one
   localparam logic [23:0] VECS [NV] = '{
      24'h02_03_A0,
      24'h0C_06_30,
      24'h00_01_55,
      24'h09_04_77,
      24'h0E_02_C3
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic host_low = 1'b0;
   logic sda_drive_low, wr_strobe;
   logic [3:0] wr_index;
   logic [7:0] wr_data;
   logic [127:0] reg_flat;
   wire sda_bus = !(host_low || sda_drive_low);

   int n_checks = 0;
   int n_fail = 0;
   int strobe_cnt = 0;
   int cycles = 0;
   int high_changes = 0;
   int addr_low_seen = 0;
   bit watch_foreign = 0;
   bit done = 0;
   logic [3:0] last_idx = '0;
   logic [7:0] last_data = '0;
   logic prev_drive = 1'b0;
   logic [7:0] model [16];

   always #2.5 clk = ~clk;

   smbus_idx_target i_smbus_idx_target (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_in        (scl),
      .sda_in        (sda_bus),
      .sda_drive_low (sda_drive_low),
      .wr_strobe     (wr_strobe),
      .wr_index      (wr_index),
      .wr_data       (wr_data),
      .reg_flat      (reg_flat)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (wr_strobe) begin
         strobe_cnt <= strobe_cnt + 1;
         last_idx   <= wr_index;
         last_data  <= wr_data;
      end
      if (sda_drive_low !== prev_drive && scl === 1'b1) high_changes <= high_changes + 1;
      if (watch_foreign && sda_drive_low) addr_low_seen <= addr_low_seen + 1;
      prev_drive <= sda_drive_low;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cycles == 190000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=finished", cycles);
         finish_run();
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      host_low = 1'b0; tick(Q);
      scl = 1'b1;      tick(Q);
      host_low = 1'b1; tick(Q);
      scl = 1'b0;      tick(Q);
   endtask

   task automatic bus_stop();
      host_low = 1'b1; tick(Q);
      scl = 1'b1;      tick(Q);
      host_low = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         host_low = !b[i]; tick(Q);
         scl = 1'b1;       tick(2*Q);
         scl = 1'b0;       tick(Q);
      end
      host_low = 1'b0; tick(Q);
      scl = 1'b1;      tick(Q);
      ack = !sda_bus;  tick(Q);
      scl = 1'b0;      tick(Q);
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      host_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl = 1'b1; tick(Q);
         b[i] = sda_bus; tick(Q);
         scl = 1'b0; tick(Q);
      end
      host_low = !nack; tick(Q);
      scl = 1'b1;       tick(2*Q);
      scl = 1'b0;       tick(Q);
      host_low = 1'b0;
   endtask

   task automatic check_bank(input string req);
      for (int r = 0; r < 16; r++)
         check(req, 32'(reg_flat[r*8 +: 8]), 32'(model[r]));
   endtask

   task automatic block_write(input logic [7:0] idx, input logic [7:0] cnt, input logic [7:0] base);
      logic ack;
      int s0;
      s0 = strobe_cnt;
      bus_start();
      send_byte(8'hDC, ack); check("R1 R3 write address ack", 32'(ack), 1);
      send_byte(idx, ack);   check("R3 index ack", 32'(ack), 1);
      send_byte(cnt, ack);   check("R3 count ack", 32'(ack), 1);
      for (int k = 0; k < int'(cnt); k++) begin
         send_byte(base + 8'(k), ack);
         check("R3 data ack", 32'(ack), 1);
         model[(int'(idx) + k) % 16] = base + 8'(k);
      end
      bus_stop();
      tick(Q);
      check_bank("R2 R5 bank after write");
      check("R11 strobe count", 32'(strobe_cnt - s0), 32'(cnt));
      if (cnt != 0) begin
         check("R11 last index", 32'(last_idx), 32'((int'(idx) + int'(cnt) - 1) % 16));
         check("R11 last data", 32'(last_data), 32'(base + cnt - 8'd1));
      end
   endtask

   // take: number of data bytes accepted; the last one is refused
   task automatic block_read(input bit set_idx, input logic [7:0] idx, input int take, input string req);
      logic ack;
      logic [7:0] b;
      int start;
      start = set_idx ? int'(idx[3:0]) : 0;
      if (set_idx) begin
         bus_start();
         send_byte(8'hDC, ack); check("R1 write address ack", 32'(ack), 1);
         send_byte(idx, ack);   check("R3 index ack", 32'(ack), 1);
      end
      bus_start();
      send_byte(8'hDD, ack); check("R1 read address ack", 32'(ack), 1);
      recv_byte(take == 0, b);
      check("R6 count byte first", 32'(b), 32'(model[8]));
      for (int k = 0; k < take; k++) begin
         recv_byte(k == take - 1, b);
         check(req, 32'(b), 32'(model[(start + k) % 16]));
      end
   endtask

   initial begin
      logic ack;
      logic [7:0] b;
      for (int r = 0; r < 16; r++) model[r] = (r == 8) ? 8'h10 : 8'h00;
      tick(10);
      rst_n = 1'b1;
      tick(10);

      // R7: reset contents and released line
      check_bank("R7 reset bank");
      check("R7 sda released after reset", 32'(sda_drive_low), 0);

      // R7 R6: read without index phase starts at 0 and returns 16 bytes
      block_read(1'b0, 8'h00, 16, "R7 R6 read from reset pointer");
      bus_stop();

      // vector table: write, then read back through repeated start (R9, R5)
      for (int v = 0; v < NV; v++) begin
         block_write(VECS[v][23:16], VECS[v][15:8], VECS[v][7:0]);
         block_read(1'b1, VECS[v][23:16], int'(model[8]), "R9 R6 R5 read data");
         bus_stop();
      end

      // R4: extra data byte refused and not stored
      bus_start();
      send_byte(8'hDC, ack); check("R1 address ack", 32'(ack), 1);
      send_byte(8'h04, ack); check("R3 index ack", 32'(ack), 1);
      send_byte(8'h01, ack); check("R3 count ack", 32'(ack), 1);
      send_byte(8'hE1, ack); check("R4 byte within count ack", 32'(ack), 1);
      model[4] = 8'hE1;
      send_byte(8'hE2, ack); check("R4 byte past count refused", 32'(ack), 0);
      bus_stop();
      tick(Q);
      check_bank("R4 bank after overflow");

      // R6: count register rewritten, then read returns that count
      block_write(8'h08, 8'h01, 8'h03);
      block_read(1'b1, 8'h0D, 3, "R6 read with count 3");
      bus_stop();

      // R8: host refuses early, target releases and ignores clocks
      block_read(1'b1, 8'h02, 2, "R8 data before refusal");
      recv_byte(1'b1, b);
      check("R8 line released after refusal", 32'(b), 32'hFF);
      bus_stop();
      tick(Q);
      check("R8 released after stop", 32'(sda_drive_low), 0);
      block_read(1'b1, 8'h00, 3, "R8 normal read after recovery");
      bus_stop();

      // R1: foreign address ignored for the whole transaction
      watch_foreign = 1;
      bus_start();
      send_byte(8'hA4, ack); check("R1 foreign address refused", 32'(ack), 0);
      send_byte(8'h00, ack); check("R1 later byte refused", 32'(ack), 0);
      recv_byte(1'b1, b);    check("R1 line stays released", 32'(b), 32'hFF);
      bus_stop();
      watch_foreign = 0;
      tick(2);
      check("R1 no drive during foreign transaction", 32'(addr_low_seen), 0);
      check_bank("R1 bank untouched by foreign write");

      // R10: drive never changed while SCL high
      check("R10 drive changes only with SCL low", 32'(high_changes), 0);

      finish_run();
   end

endmodule